// File: doc/BRIEF.md
# Raster Line and Frame Interrupt Unit

This block tracks the vertical position of the beam in a tile-based video controller. It counts scan lines within one frame and produces the 8-bit vertical position that the CPU reads. It also raises two kinds of interrupt: one near the end of the display, and one on a programmable line spacing. The horizontal timing generator sends a one-cycle pulse at the end of every scan line. Two static selects set the frame standard (262 or 313 lines) and the display height.

The line interrupt comes from an 8-bit down-counter. The counter is loaded from a software-written register and counts down once per line, but only over the active area and the single line that follows it. On every other line it is held at the register value. The frame interrupt flag is set as the beam enters the line just past the border line after the active area. Both flags stay set until the CPU reads status. They combine with per-source enables into one level-sensitive interrupt request.

The CPU-visible vertical position is a folded copy of the raw line number. It counts up from zero and then, at a mode-dependent line, jumps back to a lower value. From there it counts up to 0xFF on the last line of the frame. As a result the last line of every frame reads 0xFF.

Top module: `raster_irq_unit`

## Requirements
- R1: After reset the raw line number and the visible position are 0, both pending flags and the interrupt request are low, and both the line down-counter and its reload register hold 0xFF.
- R2: Each line-end pulse advances the raw line number by one. The number returns to 0 after line 261 when the standard select is 0 (262-line frame) and after line 312 when it is 1 (313-line frame).
- R3: The height select encodes 0 as 192 lines, 1 as 224 lines and 2 as 240 lines. Code 3 means 192 lines, and code 2 also means 192 lines when the standard select is 0.
- R4: The visible position equals the low 8 bits of the raw line number up to the fold line. From the fold line on it equals (raw line - frame length) mod 256, so the last line reads 0xFF. The fold gives these sequences: 262/192 gives 00..DA then D5..FF; 262/224 gives 00..EA then E5..FF; 313/192 gives 00..F2 then BA..FF; 313/224 gives 00..FF, 00..02, CA..FF; 313/240 gives 00..FF, 00..0A, D2..FF.
- R5: At the end of raw lines 0 through H inclusive (H = active height), the down-counter counts down by one. At the end of every other line it is loaded from the reload register.
- R6: When the down-counter is 0x00 at the end of a line in the counting window, it is loaded from the reload register instead of wrapping, and the line pending flag is set.
- R7: A write to the reload register does not change the running count. The new value is first used at the next load. A load in the same cycle as a write uses the previous register value.
- R8: The frame pending flag is set by the line-end pulse that ends raw line H, so it rises as the raw line becomes 0xC1, 0xE1 or 0xF1 for 192, 224 or 240 lines.
- R9: Each pending flag stays set until a status-read strobe clears it. A set in the same cycle as a status read leaves the flag set.
- R10: The interrupt request is high while (frame pending and frame enable) or (line pending and line enable). Dropping an enable lowers the request without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_end | input | 1 | One-cycle pulse at the end of each scan line |
| pal_mode | input | 1 | Frame standard: 0 = 262 lines, 1 = 313 lines |
| height_sel | input | 2 | Active height code (see R3) |
| reload_val | input | 8 | Data for the line-spacing reload register |
| reload_wr | input | 1 | Write strobe for the reload register |
| frame_ie | input | 1 | Frame interrupt enable |
| line_ie | input | 1 | Line interrupt enable |
| status_rd | input | 1 | Status-read strobe; clears both pending flags |
| line_num | output | 9 | Raw line number within the frame |
| vcount | output | 8 | CPU-visible vertical position |
| frame_pend | output | 1 | Frame interrupt pending |
| line_pend | output | 1 | Line interrupt pending |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the standard and height selects stay constant while the unit runs. The step check on the visible position, and the counting-window checks, depend on frame length, fold line and active height not changing between two cycles. The bench therefore changes the selects only while reset is held. Between the table entries and the directed tests it restarts from reset, so the selects always match the frame the unit is counting.

// File: rtl/raster_irq_pkg.sv
// Package: shared constants and helpers for the raster interrupt unit.
// Assumes both frame lengths lie between 256 and 511 lines.
package raster_irq_pkg;

    // Height select codes seen on the height_sel port.
    typedef enum logic [1:0] {
        HGT_192 = 2'd0,
        HGT_224 = 2'd1,
        HGT_240 = 2'd2,
        HGT_RSV = 2'd3
    } height_code_e;

    // Bit positions of the two interrupt sources in the flag vector.
    localparam int SRC_FRAME = 0;
    localparam int SRC_LINE  = 1;
    localparam int NUM_SRC   = 2;

    // Visible-position value reached right after the fold, per mode.
    localparam logic [7:0] FOLD_N192 = 8'hD5;
    localparam logic [7:0] FOLD_N224 = 8'hE5;
    localparam logic [7:0] FOLD_P192 = 8'hBA;
    localparam logic [7:0] FOLD_P224 = 8'hCA;
    localparam logic [7:0] FOLD_P240 = 8'hD2;

    // Picks the value the visible position restarts from after the fold.
    function automatic logic [7:0] fold_value(input logic pal, input logic h224, input logic h240);
        if (pal) begin
            if (h240)      return FOLD_P240;
            else if (h224) return FOLD_P224;
            else           return FOLD_P192;
        end
        return h224 ? FOLD_N224 : FOLD_N192;
    endfunction

endpackage

// File: rtl/raster_geom_decode.sv
// Module: turns the standard and height selects into frame geometry.
// Assumes both selects are static while the frame runs; the 240-line code
// is honoured only in the long-frame standard and falls back to 192.
module raster_geom_decode
    import raster_irq_pkg::*;
#(
    parameter int SHORT_LINES = 262,
    parameter int LONG_LINES  = 313,
    parameter int LINE_W      = 9
) (
    input  logic              pal_mode,
    input  logic [1:0]        height_sel,
    output logic [LINE_W-1:0] active_h,
    output logic [LINE_W-1:0] total_lines,
    output logic [LINE_W-1:0] last_line,
    output logic [LINE_W-1:0] fold_line
);

    logic       is_224;
    logic       is_240;
    logic [7:0] fold_val;

    // Decode the effective height and derive lengths and the fold line.
    always_comb begin
        is_224      = (height_code_e'(height_sel) == HGT_224);
        is_240      = (height_code_e'(height_sel) == HGT_240) && pal_mode;
        active_h    = is_240 ? LINE_W'(240) : (is_224 ? LINE_W'(224) : LINE_W'(192));
        total_lines = pal_mode ? LINE_W'(LONG_LINES) : LINE_W'(SHORT_LINES);
        last_line   = total_lines - LINE_W'(1);
        fold_val    = fold_value(pal_mode, is_224, is_240);
        fold_line   = total_lines - LINE_W'(256) + LINE_W'(fold_val);
    end

endmodule

// File: rtl/raster_line_tracker.sv
// Module: raw line counter and the folded CPU-visible vertical position.
// Assumes line_end is a single-cycle pulse and geometry is static.
module raster_line_tracker #(
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [LINE_W-1:0] active_h,
    input  logic [LINE_W-1:0] total_lines,
    input  logic [LINE_W-1:0] last_line,
    input  logic [LINE_W-1:0] fold_line,
    output logic [LINE_W-1:0] line_num,
    output logic [7:0]        vcount,
    output logic              frame_hit
);

    // Advance the raw line on each line-end pulse, wrapping after the last line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_num <= '0;
        else if (line_end)
            line_num <= (line_num == last_line) ? '0 : line_num + LINE_W'(1);
    end

    // Fold the raw line into the 8-bit visible position.
    always_comb begin
        if (line_num < fold_line)
            vcount = line_num[7:0];
        else
            vcount = line_num[7:0] - total_lines[7:0];
    end

    // Pulse when the line ending is the first line after the active area.
    always_comb frame_hit = line_end && (line_num == active_h);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && (line_num == last_line) |=> line_num == '0);

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_num <= last_line);

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && $stable(total_lines) && $stable(fold_line) &&
        (line_num != last_line) && ((line_num + LINE_W'(1)) != fold_line)
        |=> vcount == $past(vcount) + 8'd1);

    p_last_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && (line_num + LINE_W'(1) == last_line) |=> vcount == 8'hFF);

endmodule

// File: rtl/raster_line_downcounter.sv
// Module: programmable line-spacing down-counter with its reload register.
// Assumes line_end is a single-cycle pulse and active_h is static.
module raster_line_downcounter #(
    parameter int LINE_W = 9,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] active_h,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              reload_wr,
    output logic              underflow
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;
    logic             in_window;

    // Lines 0..active_h inclusive count down; all others reload.
    always_comb in_window = (line_num <= active_h);

    // Underflow occurs when a counting line ends with the count at zero.
    always_comb underflow = line_end && in_window && (count_q == '0);

    // Capture software writes to the reload register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '1;
        else if (reload_wr)
            reload_q <= reload_val;
    end

    // Count down inside the window, reload on underflow or outside it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '1;
        else if (line_end) begin
            if (!in_window || (count_q == '0))
                count_q <= reload_q;
            else
                count_q <= count_q - CNT_W'(1);
        end
    end

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(count_q));

    p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        line_end && (line_num <= active_h) && (count_q != '0)
        |=> count_q == $past(count_q) - CNT_W'(1));

    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> count_q == $past(reload_q));

    p_wr_isolated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reload_wr && !line_end |=> $stable(count_q));

endmodule

// File: rtl/raster_irq_flags.sv
// Module: sticky pending flags per source and the combined level request.
// Assumes set and clear are single-cycle strobes; set wins over clear.
module raster_irq_flags #(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic             clr_i,
    output logic [N_SRC-1:0] pend_o,
    output logic             irq_o
);

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Hold a pending flag from its set strobe until a status read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[i] <= 1'b0;
            else if (set_i[i])
                pend_o[i] <= 1'b1;
            else if (clr_i)
                pend_o[i] <= 1'b0;
        end

        p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> pend_o[i]);

        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            clr_i && !set_i[i] |=> !pend_o[i]);

        p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !set_i[i] && !clr_i |=> $stable(pend_o[i]));
    end

    // Combine enabled pending sources into one level request.
    always_comb irq_o = |(pend_o & en_i);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) && !$past(|set_i) |-> !irq_o);

endmodule

// File: rtl/raster_irq_unit.sv
// Module: top of the raster line and frame interrupt unit.
// Assumes the standard and height selects change only under reset and
// line_end is a single-cycle pulse from the horizontal timing generator.
module raster_irq_unit
    import raster_irq_pkg::*;
#(
    parameter int SHORT_LINES = 262,
    parameter int LONG_LINES  = 313,
    parameter int CNT_W       = 8,
    localparam int LINE_W     = $clog2(LONG_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic              pal_mode,
    input  logic [1:0]        height_sel,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              reload_wr,
    input  logic              frame_ie,
    input  logic              line_ie,
    input  logic              status_rd,
    output logic [LINE_W-1:0] line_num,
    output logic [7:0]        vcount,
    output logic              frame_pend,
    output logic              line_pend,
    output logic              irq
);

    logic [LINE_W-1:0]  active_h;
    logic [LINE_W-1:0]  total_lines;
    logic [LINE_W-1:0]  last_line;
    logic [LINE_W-1:0]  fold_line;
    logic               frame_hit;
    logic               underflow;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] pend_vec;

    raster_geom_decode #(
        .SHORT_LINES (SHORT_LINES),
        .LONG_LINES  (LONG_LINES),
        .LINE_W      (LINE_W)
    ) u_geom (
        .pal_mode    (pal_mode),
        .height_sel  (height_sel),
        .active_h    (active_h),
        .total_lines (total_lines),
        .last_line   (last_line),
        .fold_line   (fold_line)
    );

    raster_line_tracker #(
        .LINE_W (LINE_W)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_end    (line_end),
        .active_h    (active_h),
        .total_lines (total_lines),
        .last_line   (last_line),
        .fold_line   (fold_line),
        .line_num    (line_num),
        .vcount      (vcount),
        .frame_hit   (frame_hit)
    );

    raster_line_downcounter #(
        .LINE_W (LINE_W),
        .CNT_W  (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .line_num   (line_num),
        .active_h   (active_h),
        .reload_val (reload_val),
        .reload_wr  (reload_wr),
        .underflow  (underflow)
    );

    // Route the two sources into the flag vector.
    always_comb begin
        set_vec            = '0;
        en_vec             = '0;
        set_vec[SRC_FRAME] = frame_hit;
        set_vec[SRC_LINE]  = underflow;
        en_vec[SRC_FRAME]  = frame_ie;
        en_vec[SRC_LINE]   = line_ie;
    end

    raster_irq_flags #(
        .N_SRC (NUM_SRC)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .en_i   (en_vec),
        .clr_i  (status_rd),
        .pend_o (pend_vec),
        .irq_o  (irq)
    );

    // Expose the individual pending flags.
    always_comb begin
        frame_pend = pend_vec[SRC_FRAME];
        line_pend  = pend_vec[SRC_LINE];
    end

    p_frame_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pend) |-> line_num == active_h + LINE_W'(1));

endmodule

// File: tb/raster_irq_unit_tb.sv
`timescale 1ns/1ps
module raster_irq_unit_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_end = 1'b0;
    logic       pal_mode = 1'b0;
    logic [1:0] height_sel = 2'd0;
    logic [7:0] reload_val = 8'd0;
    logic       reload_wr = 1'b0;
    logic       frame_ie = 1'b0;
    logic       line_ie = 1'b0;
    logic       status_rd = 1'b0;
    logic [8:0] line_num;
    logic [7:0] vcount;
    logic       frame_pend;
    logic       line_pend;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    raster_irq_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .pal_mode   (pal_mode),
        .height_sel (height_sel),
        .reload_val (reload_val),
        .reload_wr  (reload_wr),
        .frame_ie   (frame_ie),
        .line_ie    (line_ie),
        .status_rd  (status_rd),
        .line_num   (line_num),
        .vcount     (vcount),
        .frame_pend (frame_pend),
        .line_pend  (line_pend),
        .irq        (irq)
    );

    // Vector: {standard, height code, lines to advance, expected vcount}.
    localparam int NV = 18;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 2'd0, 9'd218, 8'hDA}, {1'b0, 2'd0, 9'd219, 8'hD5},
        {1'b0, 2'd0, 9'd261, 8'hFF}, {1'b0, 2'd0, 9'd262, 8'h00},
        {1'b0, 2'd1, 9'd234, 8'hEA}, {1'b0, 2'd1, 9'd235, 8'hE5},
        {1'b1, 2'd0, 9'd242, 8'hF2}, {1'b1, 2'd0, 9'd243, 8'hBA},
        {1'b1, 2'd0, 9'd312, 8'hFF}, {1'b1, 2'd1, 9'd255, 8'hFF},
        {1'b1, 2'd1, 9'd256, 8'h00}, {1'b1, 2'd1, 9'd258, 8'h02},
        {1'b1, 2'd1, 9'd259, 8'hCA}, {1'b1, 2'd2, 9'd266, 8'h0A},
        {1'b1, 2'd2, 9'd267, 8'hD2}, {1'b1, 2'd2, 9'd313, 8'h00},
        {1'b0, 2'd2, 9'd219, 8'hD5}, {1'b0, 2'd3, 9'd219, 8'hD5}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pal, input logic [1:0] hs);
        @(negedge clk);
        rst_n = 1'b0; pal_mode = pal; height_sel = hs;
        line_end = 1'b0; reload_wr = 1'b0; status_rd = 1'b0;
        frame_ie = 1'b0; line_ie = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step_lines(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) line_end = 1'b1;
            @(negedge clk) line_end = 1'b0;
        end
    endtask

    task automatic write_reload(input logic [7:0] v);
        @(negedge clk) begin reload_val = v; reload_wr = 1'b1; end
        @(negedge clk) reload_wr = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
    endtask

    task automatic frame_flag_case(input logic pal, input logic [1:0] hs, input int h);
        do_reset(pal, hs);
        step_lines(h);
        check("R8 frame flag before H+1", frame_pend, 0);
        step_lines(1);
        check("R8 frame flag at H+1", frame_pend, 1);
        check("R8 line number at set", line_num, h + 1);
        check("R10 irq masked", irq, 0);
    endtask

    initial begin
        // R1: reset state
        do_reset(1'b0, 2'd0);
        @(negedge clk);
        check("R1 line_num", line_num, 0);
        check("R1 vcount", vcount, 0);
        check("R1 frame_pend", frame_pend, 0);
        check("R1 line_pend", line_pend, 0);
        check("R1 irq", irq, 0);

        // R2, R3, R4: vector table walk
        for (int k = 0; k < NV; k++) begin
            logic       v_pal;
            logic [1:0] v_hs;
            int         v_n;
            int         v_total;
            v_pal   = VEC[k][19];
            v_hs    = VEC[k][18:17];
            v_n     = int'(VEC[k][16:8]);
            v_total = v_pal ? 313 : 262;
            do_reset(v_pal, v_hs);
            step_lines(v_n);
            check("R4 R3 vcount", vcount, int'(VEC[k][7:0]));
            check("R2 line_num", line_num, v_n % v_total);
        end

        // R8, R3: frame flag line per height
        frame_flag_case(1'b0, 2'd0, 192);
        frame_flag_case(1'b0, 2'd1, 224);
        frame_flag_case(1'b1, 2'd2, 240);
        frame_flag_case(1'b0, 2'd2, 192);

        // R10, R9: enable gating and status clear (flag still set here)
        @(negedge clk) frame_ie = 1'b1;
        @(negedge clk);
        check("R10 irq with frame enable", irq, 1);
        frame_ie = 1'b0;
        @(negedge clk);
        check("R10 irq dropped by enable", irq, 0);
        check("R10 flag kept after enable drop", frame_pend, 1);
        read_status();
        check("R9 status read clears frame flag", frame_pend, 0);

        // R9: set wins over clear in the same cycle
        do_reset(1'b0, 2'd0);
        step_lines(192);
        @(negedge clk) begin line_end = 1'b1; status_rd = 1'b1; end
        @(negedge clk) begin line_end = 1'b0; status_rd = 1'b0; end
        check("R9 set beats clear", frame_pend, 1);

        // R5, R6, R7: line down-counter
        do_reset(1'b0, 2'd0);
        write_reload(8'd3);
        step_lines(262);
        check("R1 R5 no underflow from reset count", line_pend, 0);
        step_lines(3);
        check("R6 before underflow", line_pend, 0);
        step_lines(1);
        check("R6 underflow sets flag", line_pend, 1);
        check("R6 underflow line", line_num, 4);
        @(negedge clk) line_ie = 1'b1;
        @(negedge clk);
        check("R10 irq with line enable", irq, 1);
        read_status();
        check("R9 status read clears line flag", line_pend, 0);
        check("R10 irq after clear", irq, 0);
        write_reload(8'd10);
        step_lines(3);
        check("R7 write does not alter count", line_pend, 0);
        step_lines(1);
        check("R7 old count still underflows", line_pend, 1);
        read_status();
        step_lines(10);
        check("R7 new value used after reload", line_pend, 0);
        step_lines(1);
        check("R7 new spacing underflow", line_pend, 1);

        // R5: window boundary at the line after the active area
        write_reload(8'd0);
        step_lines(192 - int'(line_num));
        read_status();
        check("R5 at line 192", line_num, 192);
        check("R5 cleared before boundary", line_pend, 0);
        step_lines(1);
        check("R5 decrement on first line after active", line_pend, 1);
        read_status();
        step_lines(1);
        check("R5 reload outside window", line_pend, 0);

        // R1: reset after activity
        do_reset(1'b1, 2'd1);
        @(negedge clk);
        check("R1 line_num after re-reset", line_num, 0);
        check("R1 flags after re-reset", {frame_pend, line_pend}, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule